// File: doc/BRIEF.md
# Post-Reset Boot Release Sequencer

This block runs a one-shot start-up sequence each time its reset-request input is released. It can hold off until a management controller reports that it is present. It then hands that controller a configuration message through a doorbell mailbox and waits for the controller to consume it. Last, it takes one application processor out of reset by writing a fixed value to a reset-control register. All of this work is done as a bus master, through a single-beat 32-bit read/write port with a valid/ready handshake.

While the configuration message is pending, the block borrows a small region of memory. It first reads and keeps the words already stored there, then fills the region with a configuration image. Once the controller has acknowledged the message, it writes the kept words back. Polls that find the controller or the mailbox not ready are retried after a fixed delay, which comes from an internal down-counter. Addresses, image length, image seed and the retry delay are parameters, so the block can be scaled down for simulation.

Top module: `bootseq_top`

## Requirements
- R1: A sequence starts only on a low-to-high change of `rstReq` seen while the block is idle or done. `rstReq` is sampled through a register that resets high, so a level held high from reset starts nothing, and edges during a running sequence are ignored.
- R2: With `useFw` low, the sequence skips every controller step. The only bus access is the release write of R8, or none if no valid CPU is configured.
- R3: With `useFw` high, the block reads `STATUS_ADDR` and tests bit 4. If bit 4 is clear, the bus stays idle for exactly `DELAY_TICKS` cycles and the read is then repeated.
- R4: Before sending, the block reads `MBOX_BASE+4` until bit 16 reads 0. Each busy read is followed by `DELAY_TICKS` idle cycles.
- R5: The block reads `IMG_WORDS` words at `CFG_BASE+4*i` in ascending order of i. It then writes image word i, equal to `IMG_SEED + i*32'h00010001`, to the same addresses in the same order.
- R6: The message is six writes to `MSG_BASE+4*i` in ascending order with the data 2, 0, 0, 0, 0, 0. These are followed by a write of 32'h00010000 to `MBOX_BASE`.
- R7: After that trigger write, the block polls `MBOX_BASE+4` until bit 16 clears, pausing `DELAY_TICKS` idle cycles after each busy read. It then writes the saved words back to `CFG_BASE+4*i` in ascending order.
- R8: A `cpuIdx` of 0 to 3 causes one write of 32'h8000000E to `RSTCTL_ADDR`. An index of 32'hFFFFFFFF causes no write and no error. Any other index causes no write and sets `cfgErr`.
- R9: `done` rises once the sequence ends, and no bus access is made while `done` is high. A new start clears both `done` and `cfgErr`.
- R10: While `busValid` is high and `busReady` is low, `busValid`, `busWrite`, `busAddr` and `busWdata` stay unchanged, and the sequence does not advance.
- R11: After `rstN` is asserted, `busValid`, `done` and `cfgErr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| rstReq | input | 1 | Active-low reset request; its release starts a sequence |
| useFw | input | 1 | Enables the controller handshake steps |
| cpuIdx | input | 32 | Processor to release; all-ones means none |
| busValid | output | 1 | Bus request valid |
| busWrite | output | 1 | 1 for write, 0 for read |
| busAddr | output | 32 | Byte address |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Completes the request in the current cycle |
| busRdata | input | 32 | Read data, valid with busReady |
| done | output | 1 | Sequence finished |
| cfgErr | output | 1 | Out-of-range CPU index seen at release |

## Verification
A wrong internal state shows up on the bus at the next access. A phase that is skipped or repeated makes the transaction stream differ in address, direction or data from the order expected for the scenario. A miscounted retry wait changes the number of idle cycles between a failed poll and the next read. A broken save buffer or word counter shows up as restore data that differ from the memory's original contents. A wrong exit state shows up as a `done` or `cfgErr` level that is wrong within a cycle of the last access.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  localparam int WORD_W = 32;
  localparam int MSG_WORDS = 6;
  localparam int FW_READY_BIT = 4;
  localparam int MBOX_BUSY_BIT = 16;
  localparam logic [WORD_W-1:0] CMD_SET_CFG = 32'd2;
  localparam logic [WORD_W-1:0] TRIG_VAL = 32'h0001_0000;
  localparam logic [WORD_W-1:0] RST_RELEASE_VAL = 32'h8000_000E;
  localparam logic [WORD_W-1:0] CPU_NONE = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] IMG_STEP = 32'h0001_0001;

  typedef enum logic [3:0] {
    S_IDLE, S_FW_POLL, S_FW_WAIT, S_CFG_POLL, S_CFG_WAIT, S_SAVE, S_IMG,
    S_MSG, S_TRIG, S_ACK_POLL, S_ACK_WAIT, S_RESTORE, S_RELEASE, S_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    OP_STATUS_RD, OP_OBS_RD, OP_SAVE_RD, OP_IMG_WR,
    OP_MSG_WR, OP_TRIG_WR, OP_RESTORE_WR, OP_RST_WR
  } busOp_e;

  typedef struct packed {
    busOp_e op;
    logic   cntClr;
    logic   cntInc;
    logic   dlyLoad;
    logic   saveEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/bootseq_dp.sv
module bootseq_dp
  import bootseq_pkg::*;
#(
  parameter int IMG_WORDS = 8,
  parameter int DELAY_TICKS = 200000,
  parameter logic [31:0] CFG_BASE = 32'h0000_0000,
  parameter logic [31:0] MSG_BASE = 32'hFF99_05C0,
  parameter logic [31:0] MBOX_BASE = 32'hFF30_0000,
  parameter logic [31:0] STATUS_ADDR = 32'hFFD8_0000,
  parameter logic [31:0] RSTCTL_ADDR = 32'hFD1A_0104,
  parameter logic [31:0] IMG_SEED = 32'hC0F6_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  output logic              busWrite,
  output logic              cntLast,
  output logic              dlyDone,
  output logic              fwReady,
  output logic              mboxBusy
);

  localparam int MAX_WORDS = (IMG_WORDS > MSG_WORDS) ? IMG_WORDS : MSG_WORDS;
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int DLY_W = $clog2(DELAY_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dly;
  logic [WORD_W-1:0] saved [IMG_WORDS];
  logic [WORD_W-1:0] restoreWord;
  logic [WORD_W-1:0] byteOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dly <= '0;
    else if (strb.dlyLoad) dly <= DLY_W'(DELAY_TICKS - 1);
    else if (dly != '0) dly <= dly - 1'b1;
  end

  for (genvar g = 0; g < IMG_WORDS; g++) begin : gSave
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) saved[g] <= '0;
      else if (strb.saveEn && cnt == CNT_W'(g)) saved[g] <= busRdata;
    end
  end

  always_comb begin
    restoreWord = '0;
    for (int i = 0; i < IMG_WORDS; i++)
      if (cnt == CNT_W'(i)) restoreWord = saved[i];
  end

  assign byteOff = WORD_W'(cnt) << 2;

  always_comb begin
    busAddr  = STATUS_ADDR;
    busWdata = '0;
    busWrite = 1'b0;
    unique case (strb.op)
      OP_STATUS_RD: busAddr = STATUS_ADDR;
      OP_OBS_RD:    busAddr = MBOX_BASE + 32'd4;
      OP_SAVE_RD:   busAddr = CFG_BASE + byteOff;
      OP_IMG_WR: begin
        busAddr = CFG_BASE + byteOff; busWrite = 1'b1;
        busWdata = IMG_SEED + WORD_W'(cnt) * IMG_STEP;
      end
      OP_MSG_WR: begin
        busAddr = MSG_BASE + byteOff; busWrite = 1'b1;
        busWdata = (cnt == '0) ? CMD_SET_CFG : '0;
      end
      OP_TRIG_WR: begin
        busAddr = MBOX_BASE; busWrite = 1'b1; busWdata = TRIG_VAL;
      end
      OP_RESTORE_WR: begin
        busAddr = CFG_BASE + byteOff; busWrite = 1'b1; busWdata = restoreWord;
      end
      OP_RST_WR: begin
        busAddr = RSTCTL_ADDR; busWrite = 1'b1; busWdata = RST_RELEASE_VAL;
      end
      default: ;
    endcase
  end

  assign cntLast  = (strb.op == OP_MSG_WR) ? (cnt == CNT_W'(MSG_WORDS - 1))
                                           : (cnt == CNT_W'(IMG_WORDS - 1));
  assign dlyDone  = (dly == '0);
  assign fwReady  = busRdata[FW_READY_BIT];
  assign mboxBusy = busRdata[MBOX_BUSY_BIT];

  AST_SAVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveEn |-> cnt < CNT_W'(IMG_WORDS)) else $error("save index"); // R5
  AST_DELAY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (dly != '0 && !strb.dlyLoad) |=> dly == $past(dly) - 1'b1) else $error("delay step"); // R3

endmodule

// File: rtl/bootseq_ctrl.sv
module bootseq_ctrl
  import bootseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstReq,
  input  logic              useFw,
  input  logic [WORD_W-1:0] cpuIdx,
  input  logic              busReady,
  input  logic              cntLast,
  input  logic              dlyDone,
  input  logic              fwReady,
  input  logic              mboxBusy,
  output ctrlStrobe_t       strb,
  output logic              busValid,
  output logic              done,
  output logic              cfgErr
);

  seqState_e state, nextState;
  logic rstReqQ, rise, xfer, idxOk, startOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReqQ <= 1'b1;
    else rstReqQ <= rstReq;
  end

  assign rise    = rstReq & ~rstReqQ;
  assign startOk = rise && (state == S_IDLE || state == S_DONE);
  assign xfer    = busValid & busReady;
  assign idxOk   = cpuIdx < 32'd4;

  always_comb begin
    nextState = state;
    strb = '0;
    strb.op = OP_STATUS_RD;
    busValid = 1'b0;
    unique case (state)
      S_IDLE, S_DONE: if (startOk) begin nextState = S_FW_POLL; strb.cntClr = 1'b1; end
      S_FW_POLL: begin
        if (!useFw) nextState = S_RELEASE;
        else begin
          busValid = 1'b1; strb.op = OP_STATUS_RD;
          if (xfer) begin
            if (fwReady) nextState = S_CFG_POLL;
            else begin nextState = S_FW_WAIT; strb.dlyLoad = 1'b1; end
          end
        end
      end
      S_FW_WAIT:  if (dlyDone) nextState = S_FW_POLL;
      S_CFG_POLL: begin
        busValid = 1'b1; strb.op = OP_OBS_RD;
        if (xfer) begin
          if (mboxBusy) begin nextState = S_CFG_WAIT; strb.dlyLoad = 1'b1; end
          else begin nextState = S_SAVE; strb.cntClr = 1'b1; end
        end
      end
      S_CFG_WAIT: if (dlyDone) nextState = S_CFG_POLL;
      S_SAVE: begin
        busValid = 1'b1; strb.op = OP_SAVE_RD;
        if (xfer) begin
          strb.saveEn = 1'b1;
          if (cntLast) begin nextState = S_IMG; strb.cntClr = 1'b1; end
          else strb.cntInc = 1'b1;
        end
      end
      S_IMG: begin
        busValid = 1'b1; strb.op = OP_IMG_WR;
        if (xfer) begin
          if (cntLast) begin nextState = S_MSG; strb.cntClr = 1'b1; end
          else strb.cntInc = 1'b1;
        end
      end
      S_MSG: begin
        busValid = 1'b1; strb.op = OP_MSG_WR;
        if (xfer) begin
          if (cntLast) begin nextState = S_TRIG; strb.cntClr = 1'b1; end
          else strb.cntInc = 1'b1;
        end
      end
      S_TRIG: begin
        busValid = 1'b1; strb.op = OP_TRIG_WR;
        if (xfer) nextState = S_ACK_POLL;
      end
      S_ACK_POLL: begin
        busValid = 1'b1; strb.op = OP_OBS_RD;
        if (xfer) begin
          if (mboxBusy) begin nextState = S_ACK_WAIT; strb.dlyLoad = 1'b1; end
          else begin nextState = S_RESTORE; strb.cntClr = 1'b1; end
        end
      end
      S_ACK_WAIT: if (dlyDone) nextState = S_ACK_POLL;
      S_RESTORE: begin
        busValid = 1'b1; strb.op = OP_RESTORE_WR;
        if (xfer) begin
          if (cntLast) begin nextState = S_RELEASE; strb.cntClr = 1'b1; end
          else strb.cntInc = 1'b1;
        end
      end
      S_RELEASE: begin
        if (idxOk) begin
          busValid = 1'b1; strb.op = OP_RST_WR;
          if (xfer) nextState = S_DONE;
        end else nextState = S_DONE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else if (startOk) cfgErr <= 1'b0;
    else if (state == S_RELEASE && !idxOk && cpuIdx != CPU_NONE) cfgErr <= 1'b1;
  end

  assign done = (state == S_DONE);

  AST_IDLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !(rstReq && !rstReqQ)) |=> state == S_IDLE) else $error("idle left"); // R1
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FW_WAIT && !dlyDone) |=> state == S_FW_WAIT) else $error("wait left early"); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busValid) else $error("bus while done"); // R9

endmodule

// File: rtl/bootseq_top.sv
module bootseq_top
  import bootseq_pkg::*;
#(
  parameter int IMG_WORDS = 8,
  parameter int DELAY_TICKS = 200000,
  parameter logic [31:0] CFG_BASE = 32'h0000_0000,
  parameter logic [31:0] MSG_BASE = 32'hFF99_05C0,
  parameter logic [31:0] MBOX_BASE = 32'hFF30_0000,
  parameter logic [31:0] STATUS_ADDR = 32'hFFD8_0000,
  parameter logic [31:0] RSTCTL_ADDR = 32'hFD1A_0104,
  parameter logic [31:0] IMG_SEED = 32'hC0F6_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rstReq,
  input  logic        useFw,
  input  logic [31:0] cpuIdx,
  output logic        busValid,
  output logic        busWrite,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  input  logic        busReady,
  input  logic [31:0] busRdata,
  output logic        done,
  output logic        cfgErr
);

  ctrlStrobe_t strb;
  logic cntLast, dlyDone, fwReady, mboxBusy;

  bootseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .useFw(useFw), .cpuIdx(cpuIdx),
    .busReady(busReady), .cntLast(cntLast), .dlyDone(dlyDone),
    .fwReady(fwReady), .mboxBusy(mboxBusy), .strb(strb),
    .busValid(busValid), .done(done), .cfgErr(cfgErr)
  );

  bootseq_dp #(
    .IMG_WORDS(IMG_WORDS), .DELAY_TICKS(DELAY_TICKS), .CFG_BASE(CFG_BASE),
    .MSG_BASE(MSG_BASE), .MBOX_BASE(MBOX_BASE), .STATUS_ADDR(STATUS_ADDR),
    .RSTCTL_ADDR(RSTCTL_ADDR), .IMG_SEED(IMG_SEED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busWrite(busWrite),
    .cntLast(cntLast), .dlyDone(dlyDone), .fwReady(fwReady), .mboxBusy(mboxBusy)
  );

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid && $stable(busAddr) && $stable(busWdata)
                                && $stable(busWrite)) else $error("bus changed in stall"); // R10
  AST_RELEASE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == RSTCTL_ADDR) |->
      (busWdata == RST_RELEASE_VAL && cpuIdx < 32'd4)) else $error("bad release"); // R8
  AST_TRIGGER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == MBOX_BASE) |-> busWdata == TRIG_VAL)
    else $error("bad trigger"); // R6

endmodule

// File: tb/bootseq_top_bench.sv
module bootseq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DLY = 12;
  localparam int IMGW = 4;
  localparam logic [31:0] CFGB = 32'h0000_0000;
  localparam logic [31:0] MSGB = 32'hFF99_05C0;
  localparam logic [31:0] MBOX = 32'hFF30_0000;
  localparam logic [31:0] STAT = 32'hFFD8_0000;
  localparam logic [31:0] RSTC = 32'hFD1A_0104;
  localparam logic [31:0] SEED = 32'hC0F6_0000;

  typedef struct packed { logic w; logic [31:0] a; logic [31:0] d; } xact_t;

  logic clk = 0, rstN = 0, rstReq = 1, useFw = 0;
  logic [31:0] cpuIdx = 32'hFFFF_FFFF;
  logic busValid, busWrite, busReady = 0, done, cfgErr;
  logic [31:0] busAddr, busWdata, busRdata = 0;

  bootseq_top #(.IMG_WORDS(IMGW), .DELAY_TICKS(DLY), .CFG_BASE(CFGB), .MSG_BASE(MSGB),
    .MBOX_BASE(MBOX), .STATUS_ADDR(STAT), .RSTCTL_ADDR(RSTC), .IMG_SEED(SEED)) u_bootseq_top (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .useFw(useFw), .cpuIdx(cpuIdx),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .done(done), .cfgErr(cfgErr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  xact_t expQ[$];
  string tagQ[$];
  logic [31:0] mem [IMGW];
  logic [31:0] orig [IMGW];
  int fwBusy = 0, preBusy = 0, postBusy = 0, cyc = 0, idleRun = 0;
  bit triggered = 0, afterFail = 0, prevStall = 0, stallEn = 0, sawValid = 0;
  logic [31:0] prevA = 0, prevD = 0;
  logic prevW = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit inCfg(input logic [31:0] a);
    return a >= CFGB && a < CFGB + 32'(4 * IMGW);
  endfunction

  // memory model and per-clock reference comparison, driven at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      busReady <= 0; prevStall = 0; idleRun = 0;
    end else begin
      if (done) chk(!busValid, "R9", "bus idle while done", 64'(busValid), 0);
      if (busValid) begin
        logic rdy;
        logic [31:0] rd;
        bit fail;
        sawValid = 1;
        if (prevStall)
          chk(busAddr == prevA && busWdata == prevD && busWrite == prevW, "R10",
              "request held during stall", {busAddr, busWdata}, {prevA, prevD});
        if (afterFail) begin
          chk(idleRun == DLY, "R3", "idle cycles after failed poll", 64'(idleRun), 64'(DLY));
          afterFail = 0;
        end
        idleRun = 0;
        rdy = stallEn ? ((cyc % 3) != 0) : 1'b1;
        rd = 0; fail = 0;
        if (!busWrite) begin
          if (busAddr == STAT) begin
            if (fwBusy > 0) begin fail = 1; if (rdy) fwBusy--; end
            else rd[4] = 1;
          end else if (busAddr == MBOX + 32'd4) begin
            if (!triggered && preBusy > 0) begin rd[16] = 1; fail = 1; if (rdy) preBusy--; end
            if (triggered && postBusy > 0) begin rd[16] = 1; fail = 1; if (rdy) postBusy--; end
          end else if (inCfg(busAddr)) rd = mem[(busAddr - CFGB) >> 2];
        end
        busReady <= rdy;
        busRdata <= rd;
        if (rdy) begin
          if (expQ.size() == 0)
            chk(0, "R9", "unexpected extra transaction", {busWrite, busAddr}, 0);
          else begin
            xact_t e;
            string t;
            e = expQ.pop_front(); t = tagQ.pop_front();
            chk(e.w == busWrite && e.a == busAddr && (!e.w || e.d == busWdata), t,
                "transaction", {busWrite, busAddr, busWdata}, e);
          end
          if (busWrite && inCfg(busAddr)) mem[(busAddr - CFGB) >> 2] = busWdata;
          if (busWrite && busAddr == MBOX) triggered = 1;
          afterFail = fail;
        end
        prevStall = !rdy; prevA = busAddr; prevD = busWdata; prevW = busWrite;
      end else begin
        if (prevStall) chk(0, "R10", "valid dropped during stall", 0, 1);
        prevStall = 0;
        busReady <= 0;
        idleRun++;
      end
    end
  end

  task automatic push(input logic w, input logic [31:0] a, input logic [31:0] d, input string t);
    xact_t x;
    x.w = w; x.a = a; x.d = d;
    expQ.push_back(x); tagQ.push_back(t);
  endtask

  task automatic runSeq(input bit fw, input logic [31:0] idx, input int k, input int pre,
                        input int post, input bit stall, input bit expErr, input int seedOff,
                        input bit poke);
    string relTag;
    for (int i = 0; i < IMGW; i++) begin
      orig[i] = 32'h1234_0000 + 32'(i * 17 + seedOff);
      mem[i] = orig[i];
    end
    fwBusy = k; preBusy = pre; postBusy = post; triggered = 0; stallEn = stall;
    useFw = fw; cpuIdx = idx;
    expQ.delete(); tagQ.delete();
    if (fw) begin
      for (int i = 0; i <= k; i++) push(0, STAT, 0, "R3");
      for (int i = 0; i <= pre; i++) push(0, MBOX + 32'd4, 0, "R4");
      for (int i = 0; i < IMGW; i++) push(0, CFGB + 32'(4 * i), 0, "R5");
      for (int i = 0; i < IMGW; i++) push(1, CFGB + 32'(4 * i), SEED + 32'(i) * 32'h0001_0001, "R5");
      for (int i = 0; i < 6; i++) push(1, MSGB + 32'(4 * i), (i == 0) ? 32'd2 : 32'd0, "R6");
      push(1, MBOX, 32'h0001_0000, "R6");
      for (int i = 0; i <= post; i++) push(0, MBOX + 32'd4, 0, "R7");
      for (int i = 0; i < IMGW; i++) push(1, CFGB + 32'(4 * i), orig[i], "R7");
    end
    relTag = fw ? "R8" : "R2";
    if (idx < 32'd4) push(1, RSTC, 32'h8000_000E, relTag);
    @(negedge clk); rstReq = 0;
    repeat (3) @(negedge clk);
    rstReq = 1;
    @(negedge clk);
    chk(done == 0, "R9", "done cleared by restart", 64'(done), 0);
    chk(cfgErr == 0, "R9", "cfgErr cleared by restart", 64'(cfgErr), 0);
    for (int t = 0; t < 5000 && !done; t++) begin
      if (poke && t == 20) rstReq = 0;
      if (poke && t == 22) rstReq = 1;
      @(negedge clk);
    end
    chk(done == 1, "R9", "done after sequence", 64'(done), 1);
    chk(expQ.size() == 0, relTag, "missing transactions", 64'(expQ.size()), 0);
    chk(cfgErr == expErr, "R8", "cfgErr level", 64'(cfgErr), 64'(expErr));
    if (fw) for (int i = 0; i < IMGW; i++)
      chk(mem[i] == orig[i], "R7", "memory restored", 64'(mem[i]), 64'(orig[i]));
    repeat (6) @(negedge clk);
    chk(done == 1, "R9", "done stays high", 64'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busValid == 0 && done == 0 && cfgErr == 0, "R11", "reset outputs",
        {busValid, done, cfgErr}, 0);
    rstN = 1;
    repeat (30) @(negedge clk);
    chk(!sawValid && !done, "R1", "held-high request starts nothing", {sawValid, done}, 0);
    runSeq(0, 32'd2, 0, 0, 0, 0, 0, 0, 0);
    runSeq(1, 32'd1, 2, 1, 2, 1, 0, 5, 1);
    runSeq(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 9, 0);
    runSeq(0, 32'd7, 0, 0, 0, 1, 1, 0, 0);
    runSeq(1, 32'd3, 0, 2, 0, 1, 0, 3, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule